// File: doc/BRIEF.md
# Endian-Configurable Load/Store Byte Unit

This unit sits between a 32-bit processor datapath and a data memory that is addressed by byte but stored as 32-bit words. Each cycle it may take one request made of a base register value, a 16-bit signed offset, an operation code, store data and an endianness select. From these it forms the effective address, sends the word address, byte write strobes and write data to memory, and formats the word that memory returns into a load result.

Two word operations are supported: load word and store word. Two byte operations are supported: load byte, with sign extension, and store byte. Byte numbering inside a word follows the endianness select, so one memory image can be read in either order. A word access whose effective address is not a multiple of four raises a misalignment flag. For a store, that access also suppresses the memory write. Memory is expected to return read data in the same cycle as the word address. The load result is registered and appears one cycle after the request.

Top module: `lsu_byte_unit`

## Requirements
- R1: The effective address is base_i plus offset_i sign-extended from 16 to 32 bits, with wraparound modulo 2^32. mem_addr_o carries the effective address shifted right by two.
- R2: The low two bits of the effective address are the byte offset. Lane k means data bits 8k+7..8k. With big_endian_i=0 the lane equals the byte offset. With big_endian_i=1 the lane equals 3 minus the byte offset.
- R3: Load word (op_i=2'b00) with an aligned address returns the full memory word on ld_data_o on the clock edge that ends the request, with ld_valid_o high for that one cycle. The result is the same in both endian modes.
- R4: Load byte (op_i=2'b10) returns the byte from the selected lane, sign-extended to 32 bits. For example, after word 0x23456789 is stored at address 0, a byte load from address 1 gives 0x00000045 in big-endian mode and 0x00000067 in little-endian mode.
- R5: Store byte (op_i=2'b11) drives mem_we_o=1 and sets exactly one bit of mem_be_o, the selected lane. It places st_data_i[7:0] on that lane of mem_wdata_o and zero on the other lanes. The other three bytes of the memory word stay unchanged.
- R6: Store word (op_i=2'b01) with an aligned address drives mem_we_o=1, mem_be_o=4'b1111 and mem_wdata_o=st_data_i.
- R7: A word access with a nonzero byte offset sets misalign_o in the same cycle. For a store word, mem_we_o=0 and mem_be_o=0, so memory is unchanged. For a load word, ld_valid_o stays low on the next cycle. Byte accesses never set misalign_o.
- R8: While req_i=0, mem_we_o=0, mem_be_o=0 and misalign_o=0, and ld_valid_o is low on the next cycle.
- R9: While rst_ni is low, and after reset until the first load, ld_valid_o=0 and ld_data_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid this cycle |
| op_i | input | 2 | 00 load word, 01 store word, 10 load byte, 11 store byte |
| big_endian_i | input | 1 | 1 selects big-endian byte numbering |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed offset |
| st_data_i | input | 32 | Store data |
| mem_addr_o | output | 30 | Word address to memory |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 4 | Per-lane byte write enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data for mem_addr_o, same cycle |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Load result |
| misalign_o | output | 1 | Misaligned word access |

## Verification
In a single cycle, a store word raises the misalignment flag and also decides the write strobes. The bench provokes this with a base that is a multiple of four and an offset of two. It judges the outcome from the same-cycle strobes and from a later aligned load word, which must return the word unchanged. Byte stores and the load word that reads them back are also issued on adjacent cycles, so any lane or endian mix-up appears in the read-back word.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  typedef enum logic [1:0] {
    LSU_LW = 2'b00,
    LSU_SW = 2'b01,
    LSU_LB = 2'b10,
    LSU_SB = 2'b11
  } lsu_op_e;

  function automatic logic op_is_word(lsu_op_e op);
    return (op == LSU_LW) || (op == LSU_SW);
  endfunction

  function automatic logic op_is_load(lsu_op_e op);
    return (op == LSU_LW) || (op == LSU_LB);
  endfunction
endpackage

// File: rtl/lsu_agen.sv
`timescale 1ns/1ps
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB     = 4,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [OFF_W-1:0]         offset_i,
  input  logic                     big_endian_i,
  output logic [ADDR_W-LANE_W-1:0] word_addr_o,
  output logic [LANE_W-1:0]        byte_off_o,
  output logic [LANE_W-1:0]        lane_o
);
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] ea;

  assign off_ext     = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ea          = base_i + off_ext;
  assign word_addr_o = ea[ADDR_W-1:LANE_W];
  assign byte_off_o  = ea[LANE_W-1:0];

  // big-endian numbers bytes from the most significant lane down
  assign lane_o = big_endian_i ? (LANE_W'(NB-1) - byte_off_o) : byte_off_o;
endmodule

// File: rtl/lsu_store_fmt.sv
`timescale 1ns/1ps
module lsu_store_fmt
  import lsu_pkg::*;
#(
  parameter int NB = 4,
  localparam int LANE_W = $clog2(NB),
  localparam int DATA_W = 8*NB
) (
  input  logic              req_i,
  input  lsu_op_e           op_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              misalign_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              we_o,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic          wr_en;
  logic          word_op;
  logic [NB-1:0] be_raw;

  assign word_op = op_is_word(op_i);
  assign wr_en   = req_i && !op_is_load(op_i) && !misalign_i;
  assign we_o    = wr_en;
  assign be_o    = wr_en ? be_raw : '0;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic hit;
    assign hit       = (lane_i == LANE_W'(g));
    assign be_raw[g] = word_op || hit;
    assign wdata_o[8*g +: 8] = word_op ? st_data_i[8*g +: 8]
                             : (hit ? st_data_i[7:0] : 8'h00);
  end
endmodule

// File: rtl/lsu_load_fmt.sv
`timescale 1ns/1ps
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int NB = 4,
  localparam int LANE_W = $clog2(NB),
  localparam int DATA_W = 8*NB
) (
  input  lsu_op_e           op_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] result_o
);
  logic [7:0] bytes [NB];
  logic [7:0] sel;

  for (genvar g = 0; g < NB; g++) begin : g_split
    assign bytes[g] = rdata_i[8*g +: 8];
  end

  assign sel = bytes[lane_i];

  always_comb begin
    if (op_is_word(op_i)) result_o = rdata_i;
    else                  result_o = {{(DATA_W-8){sel[7]}}, sel};
  end
endmodule

// File: rtl/lsu_byte_unit.sv
`timescale 1ns/1ps
module lsu_byte_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W/8,
  localparam int LANE_W = $clog2(NB),
  localparam int WA_W   = ADDR_W - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic              big_endian_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [WA_W-1:0]   mem_addr_o,
  output logic              mem_we_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              misalign_o
);
  lsu_op_e           op;
  logic [LANE_W-1:0] byte_off;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] ld_fmt;
  logic              ld_take;

  assign op = lsu_op_e'(op_i);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NB(NB)) u_agen (
    .base_i      (base_i),
    .offset_i    (offset_i),
    .big_endian_i(big_endian_i),
    .word_addr_o (mem_addr_o),
    .byte_off_o  (byte_off),
    .lane_o      (lane)
  );

  assign misalign_o = req_i && op_is_word(op) && (byte_off != '0);

  lsu_store_fmt #(.NB(NB)) u_st (
    .req_i     (req_i),
    .op_i      (op),
    .lane_i    (lane),
    .misalign_i(misalign_o),
    .st_data_i (st_data_i),
    .we_o      (mem_we_o),
    .be_o      (mem_be_o),
    .wdata_o   (mem_wdata_o)
  );

  lsu_load_fmt #(.NB(NB)) u_ld (
    .op_i    (op),
    .lane_i  (lane),
    .rdata_i (mem_rdata_i),
    .result_o(ld_fmt)
  );

  assign ld_take = req_i && op_is_load(op) && !misalign_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= ld_take;
      if (ld_take) ld_data_o <= ld_fmt;
    end
  end
endmodule

// File: rtl/lsu_byte_unit_chk.sv
`timescale 1ns/1ps
module lsu_byte_unit_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [1:0]    op_i,
  input logic          mem_we_o,
  input logic [NB-1:0] mem_be_o,
  input logic          ld_valid_o,
  input logic          misalign_o
);
  // R7
  misalign_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_we_o && mem_be_o == '0));

  // R7
  byte_no_misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i[1]) |-> !misalign_o);

  // R5
  sb_one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b11) |-> (mem_we_o && $countones(mem_be_o) == 1));

  // R6
  sw_all_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b01 && !misalign_o) |-> (mem_we_o && mem_be_o == '1));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!mem_we_o && mem_be_o == '0 && !misalign_o));

  // R3
  load_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !op_i[0] && !misalign_o) |=> ld_valid_o);

  // R8
  no_load_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !op_i[0]) |=> !ld_valid_o);
endmodule

bind lsu_byte_unit lsu_byte_unit_chk #(.NB(NB)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .op_i      (op_i),
  .mem_we_o  (mem_we_o),
  .mem_be_o  (mem_be_o),
  .ld_valid_o(ld_valid_o),
  .misalign_o(misalign_o)
);

// File: tb/tb_lsu_byte_unit.sv
`timescale 1ns/1ps
module tb_lsu_byte_unit;
  import lsu_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        big_endian_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] st_data_i = '0;
  logic [29:0] mem_addr_o;
  logic        mem_we_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        ld_valid_o;
  logic [31:0] ld_data_o;
  logic        misalign_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  logic [31:0] mem [16];

  always #10 clk_i = ~clk_i;

  lsu_byte_unit dut (.*);

  assign mem_rdata_i = mem[mem_addr_o[3:0]];

  always @(posedge clk_i) begin
    if (mem_we_o)
      for (int k = 0; k < 4; k++)
        if (mem_be_o[k]) mem[mem_addr_o[3:0]][8*k +: 8] <= mem_wdata_o[8*k +: 8];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(lsu_op_e op, logic be, logic [31:0] base, logic [15:0] off,
                       logic [31:0] data);
    @(negedge clk_i);
    req_i = 1'b1; op_i = op; big_endian_i = be;
    base_i = base; offset_i = off; st_data_i = data;
    #1;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    req_i = 1'b0;
  endtask

  task automatic load_exp(string tag, lsu_op_e op, logic be, logic [31:0] base,
                          logic [15:0] off, logic [31:0] exp);
    issue(op, be, base, off, '0);
    tick();
    chk({tag, " valid"}, 32'(ld_valid_o), 32'd1);
    chk({tag, " data"}, ld_data_o, exp);
  endtask

  task automatic t_reset();
    chk("R9 valid", 32'(ld_valid_o), 32'd0);
    chk("R9 data", ld_data_o, 32'd0);
    chk("R8 idle we", 32'(mem_we_o), 32'd0);
  endtask

  task automatic t_store_word();
    // R1 R6: 0x10 + 4 = 0x14, word 5
    issue(LSU_SW, 1'b0, 32'h10, 16'h0004, 32'hCAFEF00D);
    chk("R1 addr", 32'(mem_addr_o), 32'd5);
    chk("R6 be", 32'(mem_be_o), 32'hF);
    chk("R6 we", 32'(mem_we_o), 32'd1);
    chk("R6 wdata", mem_wdata_o, 32'hCAFEF00D);
    tick();
    // R1: negative offset, 8 + (-8) = 0
    issue(LSU_SW, 1'b1, 32'h8, 16'hFFF8, 32'h23456789);
    chk("R1 neg addr", 32'(mem_addr_o), 32'd0);
    tick();
    load_exp("R3 lw word5", LSU_LW, 1'b1, 32'h14, 16'h0000, 32'hCAFEF00D);
  endtask

  task automatic t_byte_endian();
    load_exp("R4 R2 lb be", LSU_LB, 1'b1, 32'h0, 16'h0001, 32'h00000045);
    load_exp("R4 R2 lb le", LSU_LB, 1'b0, 32'h0, 16'h0001, 32'h00000067);
    issue(LSU_SW, 1'b0, 32'h8, 16'h0000, 32'h80F17F01);
    tick();
    load_exp("R4 le lane1", LSU_LB, 1'b0, 32'h8, 16'h0001, 32'h0000007F);
    load_exp("R4 le lane2 neg", LSU_LB, 1'b0, 32'hC, 16'hFFFE, 32'hFFFFFFF1);
    load_exp("R4 be lane3 neg", LSU_LB, 1'b1, 32'h8, 16'h0000, 32'hFFFFFF80);
    load_exp("R3 lw le", LSU_LW, 1'b0, 32'h8, 16'h0000, 32'h80F17F01);
    load_exp("R3 lw be", LSU_LW, 1'b1, 32'h8, 16'h0000, 32'h80F17F01);
  endtask

  task automatic t_store_byte();
    issue(LSU_SB, 1'b0, 32'h9, 16'h0000, 32'h123456AB);
    chk("R5 le be", 32'(mem_be_o), 32'h2);
    chk("R5 le wdata", mem_wdata_o, 32'h0000AB00);
    chk("R5 le we", 32'(mem_we_o), 32'd1);
    tick();
    load_exp("R5 le readback", LSU_LW, 1'b0, 32'h8, 16'h0000, 32'h80F1AB01);
    issue(LSU_SB, 1'b1, 32'h8, 16'h0000, 32'h0000005C);
    chk("R5 be be", 32'(mem_be_o), 32'h8);
    chk("R5 be wdata", mem_wdata_o, 32'h5C000000);
    tick();
    load_exp("R5 be readback", LSU_LW, 1'b1, 32'h8, 16'h0000, 32'h5CF1AB01);
  endtask

  task automatic t_misalign();
    issue(LSU_SW, 1'b0, 32'h10, 16'h0000, 32'h11223344);
    tick();
    issue(LSU_SW, 1'b0, 32'h10, 16'h0002, 32'hDEADBEEF);
    chk("R7 sw flag", 32'(misalign_o), 32'd1);
    chk("R7 sw we", 32'(mem_we_o), 32'd0);
    chk("R7 sw be", 32'(mem_be_o), 32'd0);
    tick();
    load_exp("R7 mem kept", LSU_LW, 1'b0, 32'h10, 16'h0000, 32'h11223344);
    issue(LSU_LW, 1'b1, 32'h10, 16'h0003, '0);
    chk("R7 lw flag", 32'(misalign_o), 32'd1);
    tick();
    chk("R7 lw no valid", 32'(ld_valid_o), 32'd0);
    issue(LSU_LB, 1'b0, 32'h10, 16'h0003, '0);
    chk("R7 lb no flag", 32'(misalign_o), 32'd0);
    tick();
    chk("R7 lb data", ld_data_o, 32'h00000011);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    req_i = 1'b0; op_i = LSU_SW; base_i = 32'h2; offset_i = '0; st_data_i = '1;
    #1;
    chk("R8 we", 32'(mem_we_o), 32'd0);
    chk("R8 be", 32'(mem_be_o), 32'd0);
    chk("R8 flag", 32'(misalign_o), 32'd0);
    @(posedge clk_i);
    #1;
    chk("R8 no valid", 32'(ld_valid_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    #35;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_store_word();
    t_byte_endian();
    t_store_byte();
    t_misalign();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule